// File: doc/BRIEF.md
# Selectable Half-Band Interpolation Chain

This block sits between a sample source running at the base rate and a DAC running 2, 4 or 8 times faster. It raises the sample rate of a stream of signed 16-bit samples by cascading up to three identical half-band FIR interpolators. Each interpolator doubles the rate by emitting, for every input sample, one pass-through sample and one newly computed sample midway between two neighbours. The whole chain runs on the DAC-rate clock and produces one output sample on every cycle.

A two-bit rate selector picks how many stages are active. Unused stages are bypassed and held at zero. The selector is captured only while reset or flush is asserted, and the flush also clears every delay line. The source is paced by a ready signal that is high for exactly one cycle in every 2, 4 or 8 cycles. A missing sample at that slot is replaced by zero. Data between stages keeps full precision. Only the final value is rounded and clipped to 16 bits.

Top module: `hbi_interp_chain`

## Requirements
- R1: The rate selector `mode` maps 0 to 2x (one stage), 1 to 4x (two stages), and 2 or 3 to 8x (three stages).
- R2: `in_ready` is low during reset and flush. In the first cycle after either is released it is high, and from then on it is high in exactly one cycle out of every N, where N is the active factor.
- R3: The stage input is loaded only in a cycle with `in_ready` high. It takes `in_data` when `in_valid` is 1 and a zero when `in_valid` is 0. `in_data` is ignored in all other cycles.
- R4: Each active stage turns its input stream x[m] into y[2m] = x[m-3] (pass-through phase) and y[2m+1] = the odd-phase value of R5. Stage k+1 takes as its input n the value y_k[n-1]. With S active stages, `out_data` in cycle k after release equals the rounded value of y_S[k-2].
- R5: The odd phase is (3*(x[m]+x[m-5]) - 25*(x[m-1]+x[m-4]) + 150*(x[m-2]+x[m-3])) / 256. This is an 11-tap half-band whose centre tap is one half and whose other even-offset taps are zero.
- R6: Intermediate stage values carry every fractional bit (8 more per stage). The final value is rounded to nearest, with exact halves going toward positive infinity.
- R7: After rounding, results above 32767 give 32767 and results below -32768 give -32768.
- R8: A change on `mode` while reset and flush are low does not change the active factor.
- R9: Flush zeroes `out_data` in the next cycle and clears all delay lines, so that the output restarts from an all-zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of history; captures `mode` |
| mode | input | 2 | Rate selector (0: 2x, 1: 4x, 2/3: 8x) |
| in_valid | input | 1 | Input sample present |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Input taken in this cycle |
| out_data | output | 16 | Signed output sample, one per cycle |

## Verification
The following are checked on every cycle by the assertions:
- the single-cycle ready pulse;
- the hold of the captured factor between flushes;
- the zero output two cycles after a flush;
- clipping whenever the aligned chain value lies beyond the 16-bit range.

The filter arithmetic, the phase ordering between stages, the tie rounding, the zero insertion and the disregard of data outside the ready slot can only be shown by the bench's scenarios. The bench sweeps every factor through impulses, ramps, a full-scale pattern, pseudo-random data and gaps, and compares every output cycle against an arithmetic model.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int SAMP_W  = 16;  // sample width at both edges
    localparam int COEF_W  = 9;   // signed coefficient width
    localparam int FRAC_B  = 8;   // fractional bits added by one stage
    localparam int GROW_B  = 9;   // total bits added by one stage
    localparam int NTAP_HALF = 6; // stored samples per stage (polyphase)

    // odd-phase weights, scaled by 2**FRAC_B; they sum to 128 per side
    localparam logic signed [COEF_W-1:0] W_NEAR = 9'sd150;
    localparam logic signed [COEF_W-1:0] W_MID  = -9'sd25;
    localparam logic signed [COEF_W-1:0] W_FAR  = 9'sd3;

    typedef enum logic [1:0] {
        RATE_X2  = 2'd0,
        RATE_X4  = 2'd1,
        RATE_X8  = 2'd2,
        RATE_X8A = 2'd3
    } rate_e;

    typedef struct packed {
        logic ld;    // stage takes a new input sample this cycle
        logic even;  // stage presents its pass-through phase this cycle
    } stg_ctl_t;

    function automatic logic [1:0] stages_for(rate_e r, int max_stg);
        logic [1:0] s;
        case (r)
            RATE_X2: s = 2'd1;
            RATE_X4: s = 2'd2;
            default: s = 2'd3;
        endcase
        if (int'(s) > max_stg) s = 2'(max_stg);
        return s;
    endfunction

endpackage

// File: rtl/hbi_seq.sv
module hbi_seq
    import hbi_pkg::*;
#(
    parameter int MAX_STG = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  rate_e                    mode,
    output logic [1:0]               nstg,
    output stg_ctl_t [MAX_STG-1:0]   ctl
);
    localparam int CNT_W = MAX_STG;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wrap;
    logic [1:0]       nstg_q;

    always_comb begin
        for (int b = 0; b < CNT_W; b++) wrap[b] = (b < int'(nstg_q));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q  <= '0;
            nstg_q <= stages_for(mode, MAX_STG);
        end else if (cnt_q == wrap) begin
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // stage i loads when the low (nstg - i) counter bits are zero and shows
    // its pass-through phase when counter bit (nstg - 1 - i) is set
    always_comb begin
        for (int i = 0; i < MAX_STG; i++) begin
            ctl[i].ld   = 1'b0;
            ctl[i].even = 1'b0;
            if (i < int'(nstg_q)) begin
                ctl[i].ld = 1'b1;
                for (int b = 0; b < CNT_W; b++) begin
                    if (b < int'(nstg_q) - i && cnt_q[b]) ctl[i].ld = 1'b0;
                    if (b == int'(nstg_q) - 1 - i) ctl[i].even = cnt_q[b];
                end
            end
        end
    end

    assign nstg = nstg_q;

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flush |=> $stable(nstg_q));

endmodule

// File: rtl/hbi_hb_stage.sv
module hbi_hb_stage
    import hbi_pkg::*;
#(
    parameter int IW = 16,
    localparam int OW = IW + GROW_B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  stg_ctl_t             ctl,
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    logic signed [IW-1:0] tap_q [NTAP_HALF];
    logic signed [OW-1:0] p_far, p_mid, p_near, odd_v, even_v;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < NTAP_HALF; k++) tap_q[k] <= '0;
        end else if (ctl.ld) begin
            tap_q[0] <= din;
            for (int k = 1; k < NTAP_HALF; k++) tap_q[k] <= tap_q[k-1];
        end
    end

    // modular arithmetic at OW bits is exact: |odd| <= 356/256 * |x|max
    always_comb begin
        p_far  = OW'(tap_q[0]) + OW'(tap_q[5]);
        p_mid  = OW'(tap_q[1]) + OW'(tap_q[4]);
        p_near = OW'(tap_q[2]) + OW'(tap_q[3]);
        odd_v  = p_far * OW'(W_FAR) + p_mid * OW'(W_MID) + p_near * OW'(W_NEAR);
        even_v = OW'(tap_q[3]) <<< FRAC_B;
        dout   = ctl.even ? even_v : odd_v;
    end

endmodule

// File: rtl/hbi_outfmt.sv
module hbi_outfmt
    import hbi_pkg::*;
#(
    parameter int WF = 43,
    parameter int FF = 24
) (
    input  logic signed [WF-1:0]     v,
    output logic signed [SAMP_W-1:0] y
);
    localparam logic signed [WF:0] MAXV = (WF+1)'(2**(SAMP_W-1) - 1);
    localparam logic signed [WF:0] MINV = -(WF+1)'(2**(SAMP_W-1));

    logic signed [WF:0] vr, q;

    always_comb begin
        vr = (WF+1)'(v) + ((WF+1)'(1) <<< (FF-1));
        q  = vr >>> FF;
        if (q > MAXV)      y = MAXV[SAMP_W-1:0];
        else if (q < MINV) y = MINV[SAMP_W-1:0];
        else               y = q[SAMP_W-1:0];
    end

endmodule

// File: rtl/hbi_interp_chain.sv
module hbi_interp_chain
    import hbi_pkg::*;
#(
    parameter int MAX_STG = 3   // 1..3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [1:0]               mode,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_data,
    output logic                     in_ready,
    output logic signed [SAMP_W-1:0] out_data
);
    localparam int WF = SAMP_W + GROW_B * MAX_STG;
    localparam int FF = FRAC_B * MAX_STG;
    localparam logic signed [WF:0] SAT_HI =
        ((WF+1)'(2**(SAMP_W-1)) <<< FF) - ((WF+1)'(1) <<< (FF-1));
    localparam logic signed [WF:0] SAT_LO =
        -((WF+1)'(2**(SAMP_W-1)) <<< FF) - ((WF+1)'(1) <<< (FF-1));

    logic [1:0]                 nstg;
    stg_ctl_t [MAX_STG-1:0]     ctl;
    logic signed [WF-1:0]       sx [MAX_STG];
    logic signed [WF-1:0]       chain_val;
    logic signed [SAMP_W-1:0]   fmt_y, out_q;

    hbi_seq #(.MAX_STG(MAX_STG)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .mode  (rate_e'(mode)),
        .nstg  (nstg),
        .ctl   (ctl)
    );

    for (genvar g = 0; g < MAX_STG; g++) begin : g_stg
        localparam int IWG = SAMP_W + GROW_B * g;
        localparam int OWG = IWG + GROW_B;
        logic signed [IWG-1:0] s_in;
        logic signed [OWG-1:0] s_out;
        if (g == 0) begin : g_head
            assign s_in = in_valid ? in_data : '0;
        end else begin : g_link
            assign s_in = sx[g-1][IWG-1:0];
        end
        hbi_hb_stage #(.IW(IWG)) u_stg (
            .clk  (clk),
            .rst  (rst),
            .clr  (flush),
            .ctl  (ctl[g]),
            .din  (s_in),
            .dout (s_out)
        );
        assign sx[g] = WF'(s_out);
    end

    // align the last active stage to the fixed fraction FF
    always_comb begin
        chain_val = '0;
        for (int i = 0; i < MAX_STG; i++) begin
            if (int'(nstg) == i + 1) chain_val = sx[i] <<< (FRAC_B * (MAX_STG - 1 - i));
        end
    end

    hbi_outfmt #(.WF(WF), .FF(FF)) u_fmt (.v(chain_val), .y(fmt_y));

    always_ff @(posedge clk) begin
        if (rst || flush) out_q <= '0;
        else              out_q <= fmt_y;
    end

    assign out_data = out_q;
    assign in_ready = ctl[0].ld && !rst && !flush;

    // R2
    ready_gap_chk: assert property (@(posedge clk) disable iff (rst || flush)
        in_ready |=> !in_ready);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ##1 (out_data == '0));

    // R7
    sat_hi_chk: assert property (@(posedge clk) disable iff (rst || flush)
        ((WF+1)'(chain_val) >= SAT_HI) |=> (out_data == 16'sh7fff));

    // R7
    sat_lo_chk: assert property (@(posedge clk) disable iff (rst || flush)
        ((WF+1)'(chain_val) < SAT_LO) |=> (out_data == -16'sh8000));

endmodule

// File: tb/tb_hbi_interp_chain.sv
`timescale 1ns/1ps
module tb_hbi_interp_chain;

    localparam int LEN = 512;
    localparam int M   = 40;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0, in_valid = 1'b0;
    logic [1:0] mode = 2'd0;
    logic signed [15:0] in_data = '0;
    logic in_ready;
    logic signed [15:0] out_data;

    int n_run = 0, n_fail = 0;
    longint mdl [4][LEN];
    logic signed [15:0] pv [LEN];
    logic pok [LEN];

    hbi_interp_chain dut (
        .clk(clk), .rst(rst), .flush(flush), .mode(mode),
        .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete (actual hang, expected finish)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint xin(int s, int n);
        if (n < 0) return 0;
        if (s == 1) return mdl[0][n];
        if (n - 1 < 0) return 0;
        return mdl[s-1][n-1];
    endfunction

    task automatic build_model(int stg);
        for (int n = 0; n < M; n++) mdl[0][n] = pok[n] ? longint'(pv[n]) : 0;
        for (int s = 1; s <= stg; s++) begin
            for (int t = 0; t < (M << s); t++) begin
                int m = t / 2;
                if (t % 2 == 0) mdl[s][t] = xin(s, m - 3) * 256;
                else mdl[s][t] = 3 * (xin(s, m) + xin(s, m - 5))
                               - 25 * (xin(s, m - 1) + xin(s, m - 4))
                               + 150 * (xin(s, m - 2) + xin(s, m - 3));
            end
        end
    endtask

    function automatic longint expect_out(int stg, int k);
        longint v, r;
        int f;
        if (k - 2 < 0) return 0;
        v = mdl[stg][k-2];
        f = 8 * stg;
        r = (v + (64'sd1 <<< (f - 1))) >>> f;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic fill(int pt);
        int seed = 12345;
        for (int n = 0; n < M; n++) begin
            pok[n] = 1'b1;
            pv[n]  = '0;
            case (pt)
                0: pv[n] = (n == 1) ? 16'sd12000 : 16'sd0;
                1: pv[n] = (n == 0) ? 16'sd128 : 16'sd0;
                2: pv[n] = 16'(n * 1111 - 21000);
                3: pv[n] = (n % 3 == 1) ? -16'sd32768 : 16'sd32767;
                4: begin
                    seed = seed * 1103515245 + 12345;
                    pv[n] = seed[23:8];
                    pok[n] = (n % 3 != 2);
                end
                default: begin pv[n] = 16'sd777; pok[n] = 1'b0; end
            endcase
        end
    endtask

    task automatic run_scn(int md, int pt, int md_late, string tag);
        int stg = (md == 0) ? 1 : (md == 1) ? 2 : 3;
        int nf = 1 << stg;
        fill(pt);
        build_model(stg);
        @(negedge clk);
        flush = 1'b1; mode = 2'(md); in_valid = 1'b0;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 0; k < nf * M; k++) begin
            if (k % nf == 0) begin
                in_valid = pok[k / nf];
                in_data  = pv[k / nf];
            end else begin
                in_valid = 1'b1;
                in_data  = 16'(k * 7919) ^ 16'h5a5a; // R3: must be ignored
            end
            if (k == 3) mode = 2'(md_late);          // R8 when md_late differs
            #1;
            check(in_ready == (k % nf == 0), "R1 R2 ready slot", longint'(in_ready),
                  longint'(k % nf == 0));
            check(longint'(out_data) == expect_out(stg, k), tag, longint'(out_data),
                  expect_out(stg, k));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(in_ready == 1'b0, "R2 ready low in reset", longint'(in_ready), 0);
        check(out_data == 0, "R9 reset output", longint'(out_data), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready == 1'b1, "R2 ready after reset", longint'(in_ready), 1);
        check(out_data == 0, "R9 output after reset", longint'(out_data), 0);

        run_scn(0, 0, 0, "R5 impulse 2x");
        run_scn(1, 0, 1, "R5 impulse 4x");
        run_scn(2, 0, 2, "R5 impulse 8x");
        run_scn(0, 1, 0, "R6 tie rounding 2x");
        run_scn(1, 2, 1, "R4 ramp 4x");
        run_scn(2, 2, 2, "R4 ramp 8x");
        run_scn(3, 2, 3, "R1 code 3 is 8x");
        run_scn(1, 4, 1, "R3 gaps 4x");
        run_scn(2, 4, 2, "R3 gaps 8x");
        run_scn(0, 4, 2, "R8 mode change ignored 2x");
        run_scn(1, 2, 0, "R8 mode change ignored 4x");
        run_scn(0, 3, 0, "R7 saturation 2x");
        run_scn(2, 3, 2, "R7 saturation 8x");
        run_scn(2, 5, 2, "R9 flush clears history");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule